// File: doc/BRIEF.md
# Misaligned Load/Store Unit with Selectable Byte Order

This unit connects a core's load/store requests to a byte-addressed data memory that is 64 bits wide. A request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a write flag, store data and a signed flag for loads. The unit checks the address against the access size. When the address is a multiple of the size, the access takes a single memory beat. When it is not, the access becomes two beats in consecutive cycles: the first goes to the double word that holds the start address, and the second goes to the next double word. On loads the bytes from both beats are merged. On stores each beat gets its own byte-enable mask.

A mode input chooses how object bytes map onto register bytes. In little-endian mode the byte at the lowest address is the least significant. In big-endian mode it is the most significant. The mode and all other request fields are captured when the request is accepted. Load results are widened to 64 bits with sign or zero fill. Every accepted request, load or store, gets exactly one response pulse.

The memory port writes on the clock edge when a beat is valid. Its read data is a combinational function of the beat's double-word address.

Top module: `mls_lsu`

## Requirements
- R1: `req_size` encodes the access size as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. An access of S bytes at address A is aligned exactly when A mod S = 0, so 1-byte accesses are always aligned.
- R2: An aligned request is done in one beat. The beat is presented in the acceptance cycle with `mem_addr` = A[ADDR_W-1:3]. `resp_valid` is high for exactly the next cycle, and `req_ready` stays high throughout.
- R3: A misaligned request takes two beats. The second beat comes in the cycle after acceptance, at `mem_addr` one higher than the first, wrapping at the top of the address space. `req_ready` is low during that second cycle, and `resp_valid` rises in the cycle after it.
- R4: In little-endian mode (`big_endian` = 0), the byte at address A+k is placed in load result bits [8k+7:8k], and store data bits [8k+7:8k] are written to address A+k.
- R5: In big-endian mode (`big_endian` = 1), the byte at address A+k is placed in load result bits [8(S-1-k)+7:8(S-1-k)], and store data bits [8(S-1-k)+7:8(S-1-k)] are written to address A+k.
- R6: For a load, when `req_signed` = 1, result bits above 8S-1 copy bit 8S-1. When `req_signed` = 0, those bits are zero.
- R7: Memory lane j (`mem_wdata` bits [8j+7:8j], `mem_be` bit j) holds byte address 8·`mem_addr`+j. A store sets `mem_be` bits only for its own bytes, and over all of its beats it enables exactly S bytes. No other memory byte changes.
- R8: Load beats drive `mem_write` = 0 and `mem_be` = 0.
- R9: A store's response pulse carries `resp_rdata` = 0.
- R10: While `rst_n` is low and after it is released, `resp_valid` is 0 and `req_ready` is 1. `mem_valid` is 0 until a request is presented.
- R11: Changing `big_endian` during the second beat of a misaligned access has no effect on that access. The mode captured at acceptance is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte order: 1 = big-endian, 0 = little-endian |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| req_signed | input | 1 | Load result sign-extended when 1 |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, right-justified |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 64 | Load result, zero for stores |
| mem_valid | output | 1 | Memory beat valid |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W-3 | Double-word address of the beat |
| mem_be | output | 8 | Byte-lane write enables |
| mem_wdata | output | 64 | Write data by lane |
| mem_rdata | input | 64 | Read data for `mem_addr`, same cycle |

## Verification
The bench builds the unit with ADDR_W = 8. This gives a 256-byte space, or 32 double words, small enough to mirror byte by byte in the bench. With that space, an access that starts near address 0xFF and wraps its second beat to double word 0 can be reached directly. Every store is checked against the full mirrored memory, so a stray byte enable anywhere in the space is caught.

// File: rtl/mls_pkg.sv
package mls_pkg;

  localparam int LANES = 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int WIN_LANES = 2 * LANES;

  typedef enum logic {ST_IDLE, ST_SECOND} lsu_st_e;

  typedef struct packed {
    logic [WIN_LANES*8-1:0] data;
    logic [WIN_LANES-1:0]   mask;
  } win_t;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'(1 << sz);
  endfunction

  function automatic logic is_aligned(input logic [OFF_W-1:0] off, input logic [1:0] sz);
    logic [OFF_W-1:0] low_mask;
    low_mask = OFF_W'(size_bytes(sz) - 4'd1);
    return (off & low_mask) == '0;
  endfunction

  // Spread object bytes over a two-double-word window starting at lane off.
  function automatic win_t pack_store(input logic [LANES*8-1:0] wd, input logic [OFF_W-1:0] off,
                                      input logic [1:0] sz, input logic big);
    win_t w;
    int n, lane, src;
    w = '0;
    n = int'(size_bytes(sz));
    for (int k = 0; k < LANES; k++) begin
      if (k < n) begin
        lane = int'(off) + k;
        src  = big ? (n - 1 - k) : k;
        w.data[lane*8 +: 8] = wd[src*8 +: 8];
        w.mask[lane] = 1'b1;
      end
    end
    return w;
  endfunction

  // Gather object bytes from the window and widen to a full register.
  function automatic logic [LANES*8-1:0] merge_load(input logic [WIN_LANES*8-1:0] win,
                                                    input logic [OFF_W-1:0] off, input logic [1:0] sz,
                                                    input logic big, input logic sgn);
    logic [LANES*8-1:0] res;
    logic fill;
    int n, lane, dst;
    res = '0;
    n = int'(size_bytes(sz));
    for (int k = 0; k < LANES; k++) begin
      if (k < n) begin
        lane = int'(off) + k;
        dst  = big ? (n - 1 - k) : k;
        res[dst*8 +: 8] = win[lane*8 +: 8];
      end
    end
    fill = sgn & res[n*8-1];
    for (int b = 0; b < LANES*8; b++) begin
      if (b >= n*8) res[b] = fill;
    end
    return res;
  endfunction

endpackage

// File: rtl/mls_addr_split.sv
module mls_addr_split #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [1:0]                          size,
  output logic [ADDR_W-mls_pkg::OFF_W-1:0]    dword,
  output logic [ADDR_W-mls_pkg::OFF_W-1:0]    dword_nxt,
  output logic [mls_pkg::OFF_W-1:0]           offset,
  output logic                                aligned
);
  localparam int DW_W = ADDR_W - mls_pkg::OFF_W;

  assign offset    = addr[mls_pkg::OFF_W-1:0];
  assign dword     = addr[ADDR_W-1:mls_pkg::OFF_W];
  assign dword_nxt = dword + DW_W'(1);
  assign aligned   = mls_pkg::is_aligned(offset, size);
endmodule

// File: rtl/mls_store_pack.sv
module mls_store_pack (
  input  logic [63:0]                wdata,
  input  logic [mls_pkg::OFF_W-1:0]  offset,
  input  logic [1:0]                 size,
  input  logic                       big,
  output logic [63:0]                lo_data,
  output logic [63:0]                hi_data,
  output logic [7:0]                 lo_mask,
  output logic [7:0]                 hi_mask
);
  mls_pkg::win_t win;

  assign win = mls_pkg::pack_store(wdata, offset, size, big);

  assign lo_data = win.data[63:0];
  assign hi_data = win.data[127:64];
  assign lo_mask = win.mask[7:0];
  assign hi_mask = win.mask[15:8];
endmodule

// File: rtl/mls_load_merge.sv
module mls_load_merge (
  input  logic [127:0]               window,
  input  logic [mls_pkg::OFF_W-1:0]  offset,
  input  logic [1:0]                 size,
  input  logic                       big,
  input  logic                       sgn,
  output logic [63:0]                value
);
  assign value = mls_pkg::merge_load(window, offset, size, big, sgn);
endmodule

// File: rtl/mls_lsu.sv
module mls_lsu #(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          big_endian,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [1:0]                    req_size,
  input  logic                          req_signed,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [63:0]                   req_wdata,
  output logic                          resp_valid,
  output logic [63:0]                   resp_rdata,
  output logic                          mem_valid,
  output logic                          mem_write,
  output logic [ADDR_W-4:0]             mem_addr,
  output logic [7:0]                    mem_be,
  output logic [63:0]                   mem_wdata,
  input  logic [63:0]                   mem_rdata
);
  import mls_pkg::*;

  localparam int DW_W = ADDR_W - OFF_W;

  lsu_st_e state_q;

  // Request-side decode
  logic [DW_W-1:0]  req_dword, req_dword_nxt;
  logic [OFF_W-1:0] req_off;
  logic             req_aligned;
  logic [63:0]      st_lo_data, st_hi_data;
  logic [7:0]       st_lo_mask, st_hi_mask;

  mls_addr_split #(.ADDR_W(ADDR_W)) u_split (
    .addr(req_addr), .size(req_size), .dword(req_dword), .dword_nxt(req_dword_nxt),
    .offset(req_off), .aligned(req_aligned)
  );

  mls_store_pack u_pack (
    .wdata(req_wdata), .offset(req_off), .size(req_size), .big(big_endian),
    .lo_data(st_lo_data), .hi_data(st_hi_data), .lo_mask(st_lo_mask), .hi_mask(st_hi_mask)
  );

  // Named events
  logic fire, single_done, split_start, second_beat;
  assign req_ready   = (state_q == ST_IDLE);
  assign fire        = req_valid && req_ready;
  assign single_done = fire && req_aligned;
  assign split_start = fire && !req_aligned;
  assign second_beat = (state_q == ST_SECOND);

  // Captured request for the second beat
  logic             wr_q, sgn_q, big_q;
  logic [1:0]       size_q;
  logic [OFF_W-1:0] off_q;
  logic [DW_W-1:0]  dnext_q;
  logic [63:0]      hi_data_q, lo_rd_q;
  logic [7:0]       hi_mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      sgn_q     <= 1'b0;
      big_q     <= 1'b0;
      size_q    <= '0;
      off_q     <= '0;
      dnext_q   <= '0;
      hi_data_q <= '0;
      hi_mask_q <= '0;
      lo_rd_q   <= '0;
    end else if (split_start) begin
      state_q   <= ST_SECOND;
      wr_q      <= req_write;
      sgn_q     <= req_signed;
      big_q     <= big_endian;
      size_q    <= req_size;
      off_q     <= req_off;
      dnext_q   <= req_dword_nxt;
      hi_data_q <= st_hi_data;
      hi_mask_q <= st_hi_mask;
      lo_rd_q   <= mem_rdata;
    end else if (second_beat) begin
      state_q   <= ST_IDLE;
    end
  end

  // Memory beat
  always_comb begin
    if (second_beat) begin
      mem_valid = 1'b1;
      mem_write = wr_q;
      mem_addr  = dnext_q;
      mem_be    = wr_q ? hi_mask_q : 8'h00;
      mem_wdata = hi_data_q;
    end else begin
      mem_valid = req_valid;
      mem_write = req_write;
      mem_addr  = req_dword;
      mem_be    = req_write ? st_lo_mask : 8'h00;
      mem_wdata = st_lo_data;
    end
  end

  // Load merge over the current window
  logic [127:0]     m_win;
  logic [OFF_W-1:0] m_off;
  logic [1:0]       m_size;
  logic             m_big, m_sgn, m_wr;
  logic [63:0]      m_value;

  assign m_win  = second_beat ? {mem_rdata, lo_rd_q} : {64'h0, mem_rdata};
  assign m_off  = second_beat ? off_q  : req_off;
  assign m_size = second_beat ? size_q : req_size;
  assign m_big  = second_beat ? big_q  : big_endian;
  assign m_sgn  = second_beat ? sgn_q  : req_signed;
  assign m_wr   = second_beat ? wr_q   : req_write;

  mls_load_merge u_merge (
    .window(m_win), .offset(m_off), .size(m_size), .big(m_big), .sgn(m_sgn), .value(m_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= single_done || second_beat;
      if (single_done || second_beat) resp_rdata <= m_wr ? 64'h0 : m_value;
    end
  end

  // Assertions
  p_single_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    single_done |=> resp_valid && req_ready);

  p_resp_follows_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(mem_valid));

  p_split_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    split_start |=> !req_ready && mem_valid && !resp_valid);

  p_split_next_dword_r3: assert property (@(posedge clk) disable iff (!rst_n)
    split_start |=> mem_addr == DW_W'($past(mem_addr) + 1'b1));

  p_split_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    second_beat |=> resp_valid && req_ready);

  p_store_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    single_done && req_write |-> $countones(mem_be) == int'(size_bytes(req_size)));

  p_split_store_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    split_start && req_write |=>
      ($countones(mem_be) + $countones($past(mem_be))) == int'(size_bytes($past(req_size))));

  p_load_no_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> mem_be == 8'h00);

  p_store_resp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(mem_write) |-> resp_rdata == 64'h0);

endmodule

// File: tb/mls_lsu_tb_top.sv
module mls_lsu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NDW = 1 << (AW - 3);
  localparam int NVEC = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [1:0] req_size = '0;
  logic req_signed = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic resp_valid;
  logic [63:0] resp_rdata;
  logic mem_valid, mem_write;
  logic [AW-4:0] mem_addr;
  logic [7:0] mem_be;
  logic [63:0] mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mls_lsu #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model and byte mirror
  logic [63:0] mem_arr [NDW];
  logic [7:0]  bmem [256];

  assign mem_rdata = mem_arr[mem_addr];

  always @(posedge clk) begin
    if (mem_valid && mem_write) begin
      for (int j = 0; j < 8; j++)
        if (mem_be[j]) mem_arr[mem_addr][j*8 +: 8] <= mem_wdata[j*8 +: 8];
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'((i * 7 + 3) & 255);
      mem_arr[i / 8][(i % 8)*8 +: 8] = 8'((i * 7 + 3) & 255);
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_load(input int a, input int sz, input bit sg, input bit be);
    logic [63:0] v;
    int n;
    n = 1 << sz;
    v = '0;
    for (int k = 0; k < n; k++)
      if (be) v = v | (64'(bmem[(a + k) % 256]) << (8 * (n - 1 - k)));
      else    v = v | (64'(bmem[(a + k) % 256]) << (8 * k));
    if (sg && v[8*n-1]) v = v | ~((64'h1 << (8 * n)) - 64'h1);
    if (n == 8) v = v;
    return v;
  endfunction

  task automatic model_store(input int a, input int sz, input bit be, input logic [63:0] wd);
    int n;
    n = 1 << sz;
    for (int k = 0; k < n; k++)
      bmem[(a + k) % 256] = be ? wd[8*(n-1-k) +: 8] : wd[8*k +: 8];
  endtask

  task automatic run_req(input bit we, input int sz, input bit sg, input bit be, input int a,
                         input logic [63:0] wd, input int exp_beats, input bit flip,
                         output logic [63:0] got);
    int beats;
    int n;
    logic [63:0] exp_val;
    n = 1 << sz;
    exp_val = we ? 64'h0 : model_load(a, sz, sg, be);
    @(negedge clk);
    big_endian = be; req_write = we; req_size = 2'(sz); req_signed = sg;
    req_addr = AW'(a); req_wdata = wd; req_valid = 1'b1;
    #1;
    check(req_ready == 1'b1, "R2 ready idle", 64'(req_ready), 64'h1);
    check(mem_addr == (AW-3)'(a / 8), "R7 first beat dword", 64'(mem_addr), 64'(a / 8));
    if (!we) check(mem_be == 8'h00 && !mem_write, "R8 load beat enables", 64'(mem_be), 64'h0);
    beats = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) big_endian = ~be;
    #1;
    if (!resp_valid) begin
      beats = 2;
      check(!req_ready && mem_valid, "R3 ready low during second beat", 64'(req_ready), 64'h0);
      check(mem_addr == (AW-3)'(a / 8 + 1), "R3 second beat dword", 64'(mem_addr), 64'((a / 8 + 1) % NDW));
      if (!we) check(mem_be == 8'h00 && !mem_write, "R8 second load beat", 64'(mem_be), 64'h0);
      @(negedge clk);
      #1;
    end
    check(beats == exp_beats, "R1 beat count", 64'(beats), 64'(exp_beats));
    check(resp_valid == 1'b1, "R2 response pulse", 64'(resp_valid), 64'h1);
    got = resp_rdata;
    if (we) begin
      check(resp_rdata == 64'h0, "R9 store response data", resp_rdata, 64'h0);
      model_store(a, sz, be, wd);
      for (int i = 0; i < 256; i++)
        check(mem_arr[i / 8][(i % 8)*8 +: 8] == bmem[i], "R7 memory byte",
              64'(mem_arr[i / 8][(i % 8)*8 +: 8]), 64'(bmem[i]));
    end else begin
      check(resp_rdata == exp_val, be ? "R5 R6 load value" : "R4 R6 load value", resp_rdata, exp_val);
    end
    @(negedge clk);
    check(resp_valid == 1'b0, "R2 single response cycle", 64'(resp_valid), 64'h0);
    big_endian = 1'b0;
  endtask

  // {we, size, signed, big, beats, addr, wdata}
  localparam logic [78:0] VEC [NVEC] = '{
    {1'b0, 2'd3, 1'b0, 1'b0, 2'd1, 8'h08, 64'h0},
    {1'b0, 2'd3, 1'b0, 1'b1, 2'd1, 8'h08, 64'h0},
    {1'b0, 2'd2, 1'b1, 1'b0, 2'd1, 8'h0C, 64'h0},
    {1'b0, 2'd1, 1'b0, 1'b1, 2'd2, 8'h05, 64'h0},
    {1'b0, 2'd2, 1'b1, 1'b1, 2'd2, 8'h0E, 64'h0},
    {1'b0, 2'd3, 1'b0, 1'b0, 2'd2, 8'h13, 64'h0},
    {1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 8'h21, 64'h0000_0000_89AB_CDEF},
    {1'b1, 2'd3, 1'b0, 1'b1, 2'd2, 8'h2D, 64'h0123_4567_89AB_CDEF},
    {1'b1, 2'd1, 1'b0, 1'b0, 2'd1, 8'h30, 64'h0000_0000_0000_BEEF},
    {1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 8'h37, 64'h0000_0000_0000_005A},
    {1'b0, 2'd2, 1'b1, 1'b1, 2'd2, 8'h21, 64'h0},
    {1'b0, 2'd3, 1'b0, 1'b0, 2'd2, 8'h2D, 64'h0},
    {1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 8'h37, 64'h0},
    {1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 8'h30, 64'h0},
    {1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 8'h13, 64'h0},
    {1'b1, 2'd3, 1'b0, 1'b0, 2'd1, 8'h40, 64'hFEDC_BA98_7654_3210},
    {1'b0, 2'd3, 1'b0, 1'b1, 2'd1, 8'h40, 64'h0},
    {1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 8'h3F, 64'h0}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [63:0] got;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0 && req_ready == 1'b1, "R10 in reset", 64'({resp_valid, req_ready}), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(resp_valid == 1'b0, "R10 resp idle after reset", 64'(resp_valid), 64'h0);
    check(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'h1);
    check(mem_valid == 1'b0, "R10 no beat after reset", 64'(mem_valid), 64'h0);

    for (int v = 0; v < NVEC; v++) begin
      run_req(VEC[v][78], int'(VEC[v][77:76]), VEC[v][75], VEC[v][74], int'(VEC[v][71:64]),
              VEC[v][63:0], int'(VEC[v][73:72]), 1'b0, got);
      if (v == 13)  // R5 R6 literal: big-endian signed half from bytes EF, BE
        check(got == 64'hFFFF_FFFF_FFFF_EFBE, "R5 R6 literal half", got, 64'hFFFF_FFFF_FFFF_EFBE);
      if (v == 12)  // R6 positive byte zero-filled above
        check(got == 64'h5A, "R6 positive byte", got, 64'h5A);
    end

    // R1 every offset of a 1-byte load is aligned
    for (int o = 0; o < 8; o++) run_req(1'b0, 0, 1'b0, 1'b0, 8'h48 + o, 64'h0, 1, 1'b0, got);

    // R3 wrap of the second beat to double word 0
    run_req(1'b0, 2, 1'b0, 1'b0, 8'hFE, 64'h0, 2, 1'b0, got);
    run_req(1'b1, 1, 1'b0, 1'b1, 8'hFF, 64'h0000_0000_0000_A55A, 2, 1'b0, got);
    run_req(1'b0, 1, 1'b0, 1'b0, 8'hFF, 64'h0, 2, 1'b0, got);
    check(got == 64'h5AA5, "R3 R5 wrapped store read back", got, 64'h5AA5);

    // R11 mode flip during second beat is ignored
    run_req(1'b0, 3, 1'b0, 1'b0, 8'h13, 64'h0, 2, 1'b1, got);
    run_req(1'b1, 2, 1'b0, 1'b1, 8'h52, 64'h0000_0000_1122_3344, 2, 1'b1, got);
    run_req(1'b0, 2, 1'b0, 1'b0, 8'h52, 64'h0, 2, 1'b0, got);
    check(got == 64'h4433_2211, "R11 store order kept", got, 64'h4433_2211);

    // R6 zero extension of a negative byte
    run_req(1'b0, 0, 1'b0, 1'b0, 8'h13, 64'h0, 1, 1'b0, got);
    check(got == 64'h88, "R6 unsigned byte", got, 64'h88);

    finish_run();
  end
endmodule